// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands that arrive one bit per clock cycle, lowest bit first. In every accepted cycle it takes one bit of each operand and produces one sum bit. The carry between bit positions lives in a single storage bit. A parameter selects how that storage bit is built: a D-style register loaded with the majority function, or a set/clear register. The set/clear register sets when both operand bits are 1, clears when both are 0, and otherwise keeps its value.

A word starts with a one-cycle `start` pulse, which supplies the carry-in. If `valid` is high in the same cycle, operand bit 0 is added in that cycle using the carry-in. Bits are taken only on cycles where `valid` is high; on other cycles the carry is held. A small collector shifts the sum bits into a parallel result. After the word's last bit it raises `done` for one cycle and presents the final carry on `cout`. The operands are assumed to be serialised outside the block.

Top module: `bitser_adder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sum_bit`, `sum_vld`, `result`, `cout` and `done` are all 0.
- R2: A cycle with `start` high loads `cin` as the carry. If `valid` is also high in that cycle, bit 0 is added using `cin` and the previous carry is discarded. A new `start` in the middle of a word abandons that word.
- R3: For each cycle with `valid` high, `sum_bit` on the next cycle equals a XOR b XOR carry, and `sum_vld` is 1 on that next cycle.
- R4: On a cycle with `valid` high, the carry for the next bit becomes the majority of a, b and the current carry. Over a word this gives a full ripple add.
- R5: On a cycle with `valid` low, the carry does not change and `sum_vld` is 0 on the next cycle. Operand bits on such cycles are ignored.
- R6: After WIDTH valid bits following a `start`, `result` holds the sum of the word on the next cycle, with sum bit i at result bit i. On that same cycle `cout` holds the final carry, so {cout, result} = a + b + cin.
- R7: `done` is high for exactly one cycle per completed word. `result` and `cout` keep their values until the next word completes.
- R8: The D variant (CARRY_KIND = CARRY_D, value 0) and the set/clear variant (CARRY_KIND = CARRY_SR, value 1) give identical outputs for identical inputs.
- R9: Valid bits that arrive after a word completes and before the next `start` do not raise `done` and do not change `result` or `cout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a word; loads the carry-in |
| cin | input | 1 | Carry-in sampled with `start` |
| valid | input | 1 | Operand bits are present this cycle |
| a_bit | input | 1 | Serial bit of operand a, lowest bit first |
| b_bit | input | 1 | Serial bit of operand b, lowest bit first |
| sum_bit | output | 1 | Registered serial sum bit |
| sum_vld | output | 1 | `sum_bit` was produced by the previous valid cycle |
| result | output | WIDTH | Parallel sum of the last completed word |
| cout | output | 1 | Final carry of the last completed word |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Two events can fall in the same cycle: a word start and the consumption of bit 0. When they coincide, the carry-in must replace whatever carry is stored. The bench provokes this by abandoning a partly fed word whose carry is 1 and then issuing `start` together with `valid` and a carry-in of 0. It also puts a start on the cycle right after a completion. Each word is judged against a + b + cin computed in the bench, on both carry variants side by side, bit by bit and as a parallel result.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic {
    CARRY_D  = 1'b0,
    CARRY_SR = 1'b1
  } carry_kind_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/bsa_slice.sv
module bsa_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_nxt_o
);
  always_comb begin
    s_o     = a_i ^ b_i ^ c_i;
    c_nxt_o = bsa_pkg::maj3(a_i, b_i, c_i);
  end
endmodule

// File: rtl/bsa_carry_d.sv
module bsa_carry_d (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cin,
  input  logic valid,
  input  logic c_nxt,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (valid) q <= c_nxt;
    else if (start) q <= cin;
  end
endmodule

// File: rtl/bsa_carry_sr.sv
module bsa_carry_sr (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cin,
  input  logic valid,
  input  logic a_i,
  input  logic b_i,
  output logic q
);
  logic set_c, clr_c, base_c;

  always_comb begin
    set_c  = valid & a_i & b_i;
    clr_c  = valid & ~a_i & ~b_i;
    base_c = start ? cin : q;
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_c) q <= 1'b1;
    else if (clr_c) q <= 1'b0;
    else            q <= base_c;
  end
endmodule

// File: rtl/bsa_collect.sv
module bsa_collect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             valid,
  input  logic             s_i,
  input  logic             c_nxt_i,
  output logic             sum_bit,
  output logic             sum_vld,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [WIDTH-1:0] sh_q;
  logic [CW-1:0]    cnt_q, cnt_base;
  logic             busy_q, take, last;
  logic [WIDTH-1:0] sh_nxt;

  always_comb begin
    cnt_base = start ? '0 : cnt_q;
    take     = valid & (start | busy_q);
    last     = take & (cnt_base == LAST_IDX);
    if (WIDTH > 1) sh_nxt = {s_i, sh_q[WIDTH-1:1]};
    else           sh_nxt = s_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      sum_bit <= 1'b0;
      sum_vld <= 1'b0;
      result  <= '0;
      cout    <= 1'b0;
      done    <= 1'b0;
    end else begin
      sum_vld <= valid;
      if (valid) sum_bit <= s_i;
      done <= last;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
      if (take) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_base + 1'b1;
      end
      if (last) begin
        result <= sh_nxt;
        cout   <= c_nxt_i;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
  parameter int                  WIDTH      = 8,
  parameter bsa_pkg::carry_kind_e CARRY_KIND = bsa_pkg::CARRY_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cin,
  input  logic             valid,
  input  logic             a_bit,
  input  logic             b_bit,
  output logic             sum_bit,
  output logic             sum_vld,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             done
);
  logic carry_q, c_use, s_c, c_nxt;

  always_comb c_use = start ? cin : carry_q;

  bsa_slice slice_i (
    .a_i(a_bit), .b_i(b_bit), .c_i(c_use), .s_o(s_c), .c_nxt_o(c_nxt)
  );

  generate
    if (CARRY_KIND == bsa_pkg::CARRY_SR) begin : g_sr
      bsa_carry_sr cell_i (
        .clk(clk), .rst(rst), .start(start), .cin(cin), .valid(valid),
        .a_i(a_bit), .b_i(b_bit), .q(carry_q)
      );
    end else begin : g_d
      bsa_carry_d cell_i (
        .clk(clk), .rst(rst), .start(start), .cin(cin), .valid(valid),
        .c_nxt(c_nxt), .q(carry_q)
      );
    end
  endgenerate

  bsa_collect #(.WIDTH(WIDTH)) coll_i (
    .clk(clk), .rst(rst), .start(start), .valid(valid),
    .s_i(s_c), .c_nxt_i(c_nxt),
    .sum_bit(sum_bit), .sum_vld(sum_vld), .result(result),
    .cout(cout), .done(done)
  );
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cin,
  input logic valid,
  input logic a_bit,
  input logic b_bit,
  input logic carry_q,
  input logic sum_bit,
  input logic sum_vld,
  input logic done
);
  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !valid) |=> (carry_q == $past(cin)));

  p_sum_bit_r3: assert property (@(posedge clk) disable iff (rst)
    valid |=> (sum_vld && sum_bit == ($past(a_bit) ^ $past(b_bit) ^
              ($past(start) ? $past(cin) : $past(carry_q)))));

  p_carry_maj_r4: assert property (@(posedge clk) disable iff (rst)
    valid |=> (carry_q == bsa_pkg::maj3($past(a_bit), $past(b_bit),
              ($past(start) ? $past(cin) : $past(carry_q)))));

  p_carry_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!valid && !start) |=> (carry_q == $past(carry_q) && !sum_vld));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind bitser_adder bsa_checker chk_i (
  .clk(clk), .rst(rst), .start(start), .cin(cin), .valid(valid),
  .a_bit(a_bit), .b_bit(b_bit), .carry_q(carry_q),
  .sum_bit(sum_bit), .sum_vld(sum_vld), .done(done)
);

// File: tb/bitser_adder_tb_top.sv
`timescale 1ns/1ps
module bitser_adder_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cin = 1'b0, valid = 1'b0, a_bit = 1'b0, b_bit = 1'b0;
  logic         sum_o  [2];
  logic         svld_o [2];
  logic [W-1:0] res_o  [2];
  logic         cout_o [2];
  logic         done_o [2];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bitser_adder #(.WIDTH(W), .CARRY_KIND(bsa_pkg::CARRY_D)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cin(cin), .valid(valid),
    .a_bit(a_bit), .b_bit(b_bit), .sum_bit(sum_o[0]), .sum_vld(svld_o[0]),
    .result(res_o[0]), .cout(cout_o[0]), .done(done_o[0])
  );

  bitser_adder #(.WIDTH(W), .CARRY_KIND(bsa_pkg::CARRY_SR)) dut_sr_i (
    .clk(clk), .rst(rst), .start(start), .cin(cin), .valid(valid),
    .a_bit(a_bit), .b_bit(b_bit), .sum_bit(sum_o[1]), .sum_vld(svld_o[1]),
    .result(res_o[1]), .cout(cout_o[1]), .done(done_o[1])
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Both variants are checked; the set/clear variant is tagged R8 as well.
  task automatic chk_out(input int k, input logic [63:0] act, input logic [63:0] exp,
                         input string req, input string what);
    chk(act == exp, (k == 1) ? {req, "/R8"} : req, what, act, exp);
  endtask

  task automatic test_reset_r1();
    rst = 1'b1; start = 0; valid = 0; cin = 0; a_bit = 0; b_bit = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk_out(k, {sum_o[k], svld_o[k], cout_o[k], done_o[k]}, 0, "R1", "flags after reset");
      chk_out(k, res_o[k], 0, "R1", "result after reset");
    end
  endtask

  // Feed one word; gap_pct is the chance of an idle cycle before each bit after bit 0.
  task automatic run_word(input logic [W-1:0] A, input logic [W-1:0] B,
                          input logic c, input int gap_pct);
    logic [W:0] total;
    logic       carry;
    logic       s_exp;
    total = {1'b0, A} + {1'b0, B} + {{W{1'b0}}, c};
    carry = c;
    for (int i = 0; i < W; i++) begin
      if (i > 0 && ($urandom % 100) < gap_pct) begin
        valid = 0; start = 0; a_bit = ~A[i]; b_bit = ~B[i];
        @(negedge clk);
        for (int k = 0; k < 2; k++)
          chk_out(k, svld_o[k], 0, "R5", "sum_vld after idle cycle");
      end
      start = (i == 0); cin = c; valid = 1; a_bit = A[i]; b_bit = B[i];
      s_exp = A[i] ^ B[i] ^ carry;
      carry = (A[i] & B[i]) | (A[i] & carry) | (B[i] & carry);
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        chk_out(k, {svld_o[k], sum_o[k]}, {1'b1, s_exp}, "R3/R4", "serial sum bit");
        chk_out(k, done_o[k], (i == W - 1), "R6", "done timing");
      end
    end
    start = 0; valid = 0;
    for (int k = 0; k < 2; k++)
      chk_out(k, {cout_o[k], res_o[k]}, total, "R6", "cout and result");
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk_out(k, done_o[k], 0, "R7", "done single pulse");
      chk_out(k, {cout_o[k], res_o[k]}, total, "R7", "result held");
    end
  endtask

  // Abandon a word with the carry set, then restart with start and valid together.
  task automatic test_restart_r2();
    start = 1; cin = 1; valid = 1; a_bit = 1; b_bit = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    run_word(8'h0F, 8'h01, 1'b0, 0);
  endtask

  task automatic test_idle_bits_r9();
    logic [W:0] held;
    held = {cout_o[0], res_o[0]};
    for (int i = 0; i < W + 2; i++) begin
      start = 0; valid = 1; a_bit = 1; b_bit = i[0];
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        chk_out(k, done_o[k], 0, "R9", "no done from stray bits");
        chk_out(k, {cout_o[k], res_o[k]}, held, "R9", "result untouched");
      end
    end
    valid = 0;
    @(negedge clk);
  endtask

  task automatic test_random();
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] A, B;
      A = W'($urandom);
      B = W'($urandom);
      run_word(A, B, n[0], 25);
    end
  endtask

  initial begin
    test_reset_r1();
    run_word(8'h00, 8'h00, 1'b0, 0);
    run_word(8'hFF, 8'h00, 1'b1, 0);
    run_word(8'hFF, 8'hFF, 1'b1, 0);
    run_word(8'hA5, 8'h5A, 1'b0, 50);
    test_restart_r2();
    run_word(8'h80, 8'h80, 1'b0, 0);
    test_idle_bits_r9();
    run_word(8'h7F, 8'h01, 1'b1, 30);
    test_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule